// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block records the moment an external signal changes. A free-running up-counter elsewhere on the chip feeds its value in. When the capture pin shows an edge of the chosen polarity, the unit stores the counter's upper byte in a capture register that software can only read. It then raises a pending flag and, if interrupts are enabled, an interrupt line.

The pin is asynchronous to the block's clock, so it first passes through a synchroniser. Edges are detected on the synchronised copy. After a capture the unit stays locked: any later edge is dropped until software reads the captured byte. That read clears the flag and re-arms the unit. An edge that arrives in the same cycle as the read is not lost. It is accepted as a fresh capture, and the flag stays set.

Top module: `icap_unit`

## Requirements
- R1: With `edge_sel` = 0, a low-to-high transition of the synchronised pin stores `cnt_val[CNT_W-1:CNT_W-8]` into `cap_data`.
- R2: With `edge_sel` = 1, a high-to-low transition of the synchronised pin stores the counter's upper byte into `cap_data`. A transition of the other polarity captures nothing.
- R3: Every accepted capture sets `cap_flag` on the clock edge that loads `cap_data`.
- R4: `irq` is high exactly when `cap_flag` and `irq_en` are both high.
- R5: A cycle with `rd_strobe` high and no edge detected clears `cap_flag` at the next clock edge and leaves `cap_data` unchanged. `cap_flag` never falls without a read in the cycle before.
- R6: While `cap_flag` is set and `rd_strobe` is low, detected edges leave `cap_data` and `cap_flag` unchanged.
- R7: An edge detected in the same cycle as `rd_strobe` is accepted. `cap_data` takes the new counter byte and `cap_flag` stays high.
- R8: A pin level first sampled at rising clock edge k reaches the detector through two flip-flops. The capture happens at edge k+2 and stores the counter value present at that edge.
- R9: A synchronous active-low reset clears `cap_data`, `cap_flag` and `irq` to zero and sets the synchroniser to a low pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| edge_sel | input | 1 | 0 = capture on rising edge, 1 = capture on falling edge |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the capture register |
| cnt_val | input | CNT_W | Value of the free-running counter |
| cap_data | output | 8 | Captured counter upper byte |
| cap_flag | output | 1 | Capture pending, not yet read |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle the following behaviours:
- The lock-out (R6): the stored byte holds while the flag is up and no read arrives.
- The flag can only fall after a read (R5).
- A detected, permitted edge sets the flag and loads the byte the counter showed (R1, R3).

Other behaviours cover several cycles and only the bench scenarios can show them:
- The two-cycle synchroniser delay (R8).
- Polarity selection (R2).
- The same-cycle edge and read (R7).
- The reset values (R9).

For these, directed sequences are mixed with long random stretches. A reference model predicts every output.

// File: rtl/icap_pkg.sv
// Package: shared types for the edge capture unit.
// Assumes: single clock domain after the pin synchroniser.
package icap_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } icap_edge_e;
endpackage

// File: rtl/icap_sync.sv
// Module: multi-stage flip-flop synchroniser for one asynchronous bit.
// Assumes: the input is asynchronous. Reset drives every stage to 0.
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/icap_edge_det.sv
// Module: polarity-selectable edge detector on a synchronised level.
// Assumes: lvl is already synchronous. The pulse is combinational for one cycle.
module icap_edge_det
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  icap_edge_e pol,
    output logic       hit
);
    logic prev;

    // Hold the level from the previous cycle for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    // Raise a pulse when the transition matches the chosen polarity.
    always_comb begin
        unique case (pol)
            EDGE_RISE: hit = lvl & ~prev;
            EDGE_FALL: hit = ~lvl & prev;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_latch.sv
// Module: capture register and pending flag, with lock-out while unread.
// Assumes: hit is a one-cycle pulse. rd is a one-cycle read strobe.
module icap_latch #(
    parameter int CNT_W = 16,
    parameter int CAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             rd,
    input  logic [CNT_W-1:0] cnt,
    output logic [CAP_W-1:0] data,
    output logic             flag
);
    localparam int MSB = CNT_W - 1;
    localparam int LSB = CNT_W - CAP_W;

    logic             accept;
    logic [CAP_W-1:0] cnt_hi;

    // Take the upper slice of the counter.
    assign cnt_hi = cnt[MSB:LSB];

    // Accept an edge when nothing is pending or the pending byte is being read now.
    assign accept = hit & (~flag | rd);

    // Load the byte on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      data <= '0;
        else if (accept) data <= cnt_hi;
    end

    // Set the flag on capture and clear it on a read that has no capture with it.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (accept) flag <= 1'b1;
        else if (rd)     flag <= 1'b0;
    end

    // R6
    hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd) |=> $stable(data));

    // R3
    flag_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flag) |=> flag);

    // R5
    flag_drop_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd) |=> flag);

    // R1
    loads_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (!flag || rd)) |=> (data == $past(cnt[MSB:LSB])));
endmodule

// File: rtl/icap_unit.sv
// Module: top of the edge capture unit. Synchroniser, edge detector and latch.
// Assumes: cnt_val is a free-running counter in the clk domain.
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             edge_sel,
    input  logic             irq_en,
    input  logic             rd_strobe,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [7:0]       cap_data,
    output logic             cap_flag,
    output logic             irq
);
    localparam int CAP_W = 8;

    logic       pin_s;
    logic       edge_hit;
    icap_edge_e pol;

    assign pol = icap_edge_e'(edge_sel);

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_pin),
        .dout (pin_s)
    );

    icap_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pin_s),
        .pol  (pol),
        .hit  (edge_hit)
    );

    icap_latch #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (edge_hit),
        .rd   (rd_strobe),
        .cnt  (cnt_val),
        .data (cap_data),
        .flag (cap_flag)
    );

    // Request an interrupt while a capture is pending and enabled.
    assign irq = cap_flag & irq_en;

    // R4
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_flag && irq_en));
endmodule

// File: tb/sim_icap_unit.sv
`timescale 1ns/100ps
module sim_icap_unit;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_pin = 1'b0;
    logic             edge_sel = 1'b0;
    logic             irq_en = 1'b0;
    logic             rd_strobe = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic [7:0]       cap_data;
    logic             cap_flag;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    // Reference model state
    logic       m_s1 = 0, m_s2 = 0, m_prev = 0, m_flag = 0;
    logic [7:0] m_data = 0;

    always #2.5 clk = ~clk;

    icap_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_sel(edge_sel),
        .irq_en(irq_en), .rd_strobe(rd_strobe), .cnt_val(cnt_val),
        .cap_data(cap_data), .cap_flag(cap_flag), .irq(irq)
    );

    function automatic logic f_hit(logic s2, logic prev, logic sel);
        return sel ? (!s2 && prev) : (s2 && !prev);
    endfunction

    function automatic logic [7:0] f_hi(logic [CNT_W-1:0] c);
        return c[CNT_W-1 -: 8];
    endfunction

    // Model update at each rising edge. Inputs are stable here.
    always @(posedge clk) begin
        logic h, acc;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_data = 0;
        end else begin
            h   = f_hit(m_s2, m_prev, edge_sel);
            acc = h && (!m_flag || rd_strobe);
            if (acc) begin
                m_data = f_hi(cnt_val);
                m_flag = 1;
            end else if (rd_strobe) begin
                m_flag = 0;
            end
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = cap_pin;
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare all outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R1/R2 cap_data vs model", cap_data, m_data);
            chk("R3/R5 cap_flag vs model", {7'b0, cap_flag}, {7'b0, m_flag});
            chk("R4 irq vs model", {7'b0, irq}, {7'b0, m_flag & irq_en});
        end
    end

    // Advance one cycle. Inputs set after this call are seen at the next rising edge.
    task automatic tick();
        @(negedge clk);
        #1;
        cnt_val = cnt_val + 16'h0137;
    endtask

    initial begin
        logic [7:0] exp;
        rst_n = 0;
        repeat (3) tick();
        chk("R9 reset cap_data", cap_data, 8'h00);
        chk("R9 reset cap_flag", {7'b0, cap_flag}, 8'h00);
        chk("R9 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1;
        model_on = 1;
        repeat (3) tick();

        // R8: latency through the synchroniser, rising polarity, interrupt enabled
        irq_en = 1; edge_sel = 0; cap_pin = 1;
        tick();
        chk("R8 no flag after edge k", {7'b0, cap_flag}, 8'h00);
        tick();
        chk("R8 no flag after edge k+1", {7'b0, cap_flag}, 8'h00);
        exp = f_hi(cnt_val);
        tick();
        chk("R8 flag at edge k+2", {7'b0, cap_flag}, 8'h01);
        chk("R1 captured byte", cap_data, exp);
        chk("R4 irq raised", {7'b0, irq}, 8'h01);

        // R6: a falling edge while the flag is pending is ignored
        edge_sel = 1; cap_pin = 0;
        repeat (5) tick();
        chk("R6 data held while pending", cap_data, exp);
        chk("R6 flag held while pending", {7'b0, cap_flag}, 8'h01);

        // R5: a read with no edge clears the flag and keeps the data
        rd_strobe = 1; tick(); rd_strobe = 0;
        chk("R5 flag cleared by read", {7'b0, cap_flag}, 8'h00);
        chk("R5 data kept by read", cap_data, exp);
        irq_en = 0;

        // R2: with falling polarity a rising edge captures nothing
        cap_pin = 1;
        repeat (5) tick();
        chk("R2 wrong polarity ignored", {7'b0, cap_flag}, 8'h00);
        cap_pin = 0;
        tick(); tick();
        exp = f_hi(cnt_val);
        tick();
        chk("R2 falling capture byte", cap_data, exp);
        chk("R2 falling capture flag", {7'b0, cap_flag}, 8'h01);

        // R7: an edge in the same cycle as the read is accepted
        edge_sel = 0; cap_pin = 1;
        tick(); tick();
        rd_strobe = 1;
        exp = f_hi(cnt_val);
        tick();
        rd_strobe = 0;
        chk("R7 flag stays set", {7'b0, cap_flag}, 8'h01);
        chk("R7 new byte loaded", cap_data, exp);

        // Random phase with a fixed seed
        void'($urandom(32'h1c4e));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) cap_pin = ~cap_pin;
            rd_strobe = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 40) == 0) edge_sel = ~edge_sel;
            if ($urandom_range(0, 10) == 0) irq_en = ~irq_en;
            if (i == 2000) rst_n = 0;
            if (i == 2002) rst_n = 1;
            tick();
            if (i == 2001) begin
                chk("R9 mid-run reset data", cap_data, 8'h00);
                chk("R9 mid-run reset flag", {7'b0, cap_flag}, 8'h00);
            end
        end
        rd_strobe = 0;
        tick();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule